// File: doc/BRIEF.md
# Synthesiser Lock Indicator

This block watches two single-cycle pulse trains inside a frequency synthesiser: the divided reference and the divided oscillator. Both pulse trains must already be synchronous to the block clock. The block works out how far apart each reference edge and its nearest oscillator edge are, counted in block-clock ticks. If they fall within a tolerance window, that comparison counts as a hit. One configuration bit chooses a narrow window or a wide window. The block raises a lock flag once enough hits in a row have been seen.

Two behaviours are available for the flag. In tracking mode it reflects the current run of hits and drops on the first miss. In latching mode it stays high once set, until the synthesiser is reprogrammed or put in reset. Turning detection off forces the flag high. A low flag gives no guarantee that the loop has lost lock. Software pulses the reprogram input each time it rewrites the synthesiser settings.

Top module: `pll_lock_monitor`

## Requirements
- R1: After reset, with detection enabled and no pulses applied, `lock` is 0.
- R2: A comparison is a hit when the oscillator edge arrives at most W ticks before or after the reference edge. W is 4 when `win_wide` is 0 and 9 when `win_wide` is 1. A distance of W+1 is a miss.
- R3: A reference edge with no oscillator edge within W ticks on either side is a miss, and it clears the run of consecutive hits.
- R4: `lock` is asserted only after 4 consecutive hits. Three hits are not enough.
- R5: With `single_shot` = 0 (tracking), `lock` falls to 0 after the first miss.
- R6: With `single_shot` = 1 (latching), `lock` stays 1 after it has been set, even through later misses.
- R7: A one-cycle pulse on `reprog` clears the run of hits and any latched lock, so `lock` reads 0 afterwards.
- R8: With `detect_en` = 0, `lock` is 1 whatever the other inputs are, including `synth_rst`.
- R9: While `synth_rst` is 1 and detection is enabled, `lock` is 0 and hits are not counted. After release, 4 new hits are needed before `lock` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock that sets the tick size |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_pulse | input | 1 | Divided reference pulse, synchronous to clk |
| vco_pulse | input | 1 | Divided oscillator pulse, synchronous to clk |
| win_wide | input | 1 | 1 selects the wide tolerance window |
| single_shot | input | 1 | 1 selects latching mode, 0 selects tracking mode |
| detect_en | input | 1 | 0 disables detection and forces lock high |
| synth_rst | input | 1 | Synthesiser reset; holds the counters cleared |
| reprog | input | 1 | One-cycle pulse sent when settings are rewritten |
| lock | output | 1 | Lock indication |

## Verification
The run of hits is the state most likely to go wrong, and it can only be seen through `lock`. A count that does not clear on a miss shows up as `lock` rising too early, within one reference period of the miss. A window that is off by one tick shows up as a boundary row at distance W or W+1 reporting the wrong flag at the end of that period. A latch that does not clear on `reprog` or `synth_rst` shows up at once as `lock` staying high. A latch that clears by mistake shows up after the first miss in latching mode.

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor #(
  parameter int NARROW_TICKS = 4,
  parameter int WIDE_TICKS   = 9,
  parameter int LOCK_COUNT   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_pulse,
  input  logic vco_pulse,
  input  logic win_wide,
  input  logic single_shot,
  input  logic detect_en,
  input  logic synth_rst,
  input  logic reprog,
  output logic lock
);
  localparam int TW = $clog2(WIDE_TICKS + 2);
  localparam int CW = $clog2(LOCK_COUNT + 1);
  localparam logic [TW-1:0] AGE_MAX = {TW{1'b1}};
  localparam logic [CW-1:0] FULL = CW'(LOCK_COUNT);

  logic ref_q, vco_q;
  logic waiting, vco_free, latched;
  logic [TW-1:0] wcnt, age;
  logic [CW-1:0] cnt;

  wire [TW-1:0] win = win_wide ? TW'(WIDE_TICKS) : TW'(NARROW_TICKS);
  wire ref_rise = ref_pulse & ~ref_q;
  wire vco_rise = vco_pulse & ~vco_q;
  wire clr      = reprog | synth_rst;
  wire lead_hit = ref_rise & (vco_rise | (vco_free & (age <= win)));
  wire lag_hit  = waiting & ~ref_rise & vco_rise;
  wire stale    = waiting & ref_rise;
  wire time_out = waiting & ~ref_rise & ~vco_rise & (wcnt >= win);
  wire hit      = lead_hit | lag_hit;
  wire miss     = stale | time_out;
  wire full     = (cnt == FULL);

  assign lock = !detect_en ? 1'b1 :
                synth_rst  ? 1'b0 :
                (full | (single_shot & latched));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q    <= 1'b0;
      vco_q    <= 1'b0;
      waiting  <= 1'b0;
      wcnt     <= '0;
      vco_free <= 1'b0;
      age      <= '0;
      cnt      <= '0;
      latched  <= 1'b0;
    end else begin
      ref_q <= ref_pulse;
      vco_q <= vco_pulse;
      if (clr) begin
        waiting  <= 1'b0;
        wcnt     <= '0;
        vco_free <= 1'b0;
        age      <= '0;
        cnt      <= '0;
        latched  <= 1'b0;
      end else begin
        if (ref_rise) begin
          waiting <= ~lead_hit;
          wcnt    <= TW'(1);
        end else if (waiting) begin
          if (vco_rise || wcnt >= win) waiting <= 1'b0;
          else wcnt <= wcnt + 1'b1;
        end

        if (vco_rise && !ref_rise && !waiting) begin
          vco_free <= 1'b1;
          age      <= TW'(1);
        end else if (hit) begin
          vco_free <= 1'b0;
        end else if (vco_free && age != AGE_MAX) begin
          age <= age + 1'b1;
        end

        if (hit)       cnt <= stale ? CW'(1) : (full ? FULL : cnt + 1'b1);
        else if (miss) cnt <= '0;

        latched <= latched | (single_shot & full);
      end
    end
  end

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reprog |=> (cnt == '0 && !latched));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    synth_rst |=> (cnt == '0 && !waiting));
  assert_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && !hit && !clr) |=> cnt == '0);
  assert_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && !clr) |=> latched);
  assert_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !stale && !clr && cnt == FULL - 1'b1) |=> full);
endmodule

// File: tb/pll_lock_monitor_test.sv
`timescale 1ns/1ps
module pll_lock_monitor_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_pulse = 1'b0, vco_pulse = 1'b0, win_wide = 1'b0;
  logic single_shot = 1'b0, detect_en = 1'b1, synth_rst = 1'b0, reprog = 1'b0;
  logic lock;
  int checks = 0, errors = 0;

  localparam int NONE = 100;
  // columns: wide, oscillator offset in ticks (NONE = absent), expected lock
  localparam int ROWS [20][3] = '{
    '{0, 0, 0}, '{0, -4, 0}, '{0, 4, 0}, '{0, 2, 1},
    '{0, 5, 0}, '{0, -3, 0}, '{0, 1, 0}, '{0, -1, 0},
    '{0, NONE, 0}, '{1, 9, 0}, '{1, -9, 0}, '{1, 6, 0},
    '{1, -7, 1}, '{1, 10, 0}, '{1, -10, 0}, '{0, -5, 0},
    '{1, 0, 0}, '{1, 0, 0}, '{1, 0, 0}, '{1, 0, 1}
  };

  always #2.5 clk = ~clk;

  pll_lock_monitor uut (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .vco_pulse(vco_pulse),
    .win_wide(win_wide), .single_shot(single_shot), .detect_en(detect_en),
    .synth_rst(synth_rst), .reprog(reprog), .lock(lock)
  );

  task automatic check(input logic exp, input string req);
    checks++;
    if (lock !== exp) begin
      errors++;
      $display("FAIL %s: lock=%b expected=%b", req, lock, exp);
    end
  endtask

  task automatic period(input logic wide, input int d);
    win_wide = wide;
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      ref_pulse = (k == 16);
      vco_pulse = (d != NONE) && (k == 16 + d);
    end
    @(negedge clk);
    ref_pulse = 1'b0;
    vco_pulse = 1'b0;
  endtask

  task automatic pulse_reprog();
    @(negedge clk); reprog = 1'b1;
    @(negedge clk); reprog = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b0, "R1 reset state");

    for (int i = 0; i < 20; i++) begin
      period(ROWS[i][0][0], ROWS[i][1]);
      check(ROWS[i][2][0], $sformatf("R2 R3 R4 R5 row %0d", i));
    end

    pulse_reprog();
    check(1'b0, "R7 reprog clears tracking count");

    single_shot = 1'b1;
    for (int i = 0; i < 3; i++) period(1'b0, 0);
    check(1'b0, "R4 three hits not enough");
    period(1'b0, 0);
    check(1'b1, "R4 fourth hit latches");
    period(1'b0, NONE);
    period(1'b0, 7);
    check(1'b1, "R6 latch survives misses");

    pulse_reprog();
    check(1'b0, "R7 reprog clears latch");
    for (int i = 0; i < 3; i++) period(1'b0, -2);
    check(1'b0, "R7 count restarted");
    period(1'b0, 3);
    check(1'b1, "R4 relock after reprog");

    @(negedge clk); synth_rst = 1'b1;
    @(negedge clk);
    check(1'b0, "R9 synth reset forces low");
    for (int i = 0; i < 4; i++) period(1'b0, 0);
    check(1'b0, "R9 hits ignored in synth reset");
    detect_en = 1'b0;
    @(negedge clk);
    check(1'b1, "R8 disable overrides synth reset");
    detect_en = 1'b1;
    @(negedge clk); synth_rst = 1'b0;
    for (int i = 0; i < 3; i++) period(1'b0, 1);
    check(1'b0, "R9 count held at zero");
    period(1'b0, 1);
    check(1'b1, "R9 relock after release");

    single_shot = 1'b0;
    detect_en = 1'b0;
    period(1'b0, NONE);
    check(1'b1, "R8 disabled stays high through miss");
    detect_en = 1'b1;
    @(negedge clk);
    check(1'b0, "R5 miss cleared tracking lock");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule